// File: doc/BRIEF.md
# Strobed Three-Wire Register Loader

This block receives configuration words over a three-wire serial port (serial clock, serial data and a load strobe) and keeps them in two 32-bit control registers. Every rising serial clock shifts one data bit into a 32-bit word. Bits arrive low bit first, so the bit that comes in first ends up in position 0 once the whole word is in. A rising strobe commits the word. Its two lowest bits select the destination register, and the complete word, address bits included, is copied there.

The three serial lines have no fixed timing relation to the system clock. They are synchronised into the system clock domain and their edges are detected there. The serial clock period must cover at least four system clocks. A one-cycle clear input from the calibration logic knocks down the start bit in the second register. The register words are brought out whole, and the most used fields are also brought out as separate ports.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, the first register reads 0x006ABF10 (gain field [14:10] = 15, cutoff field [21:15] = 85) and the second register reads 0x71F80805 (both DAC fields [11:4] and [19:12] = 128, mode bit 2 set, start bit 3 clear).
- R2: Each detected rising edge of the serial clock shifts the synchronised data bit into bit 31 and moves every other bit down by one position. After 32 shifts, the first bit sent sits at bit 0.
- R3: The shift word changes only on a rising serial clock edge. Data that changes while the serial clock is high, and falling serial clock edges, have no effect.
- R4: A rising strobe copies the shift word into register 0 when bits [1:0] are 0, or into register 1 when they are 1. If the strobe input goes high just before system clock edge k, the register holds the new word after edge k+2. Without a strobe edge, no register changes.
- R5: A word whose bits [1:0] are 2 or 3 changes neither register.
- R6: A strobe that arrives after fewer than 32 shifts still commits the shift word as it stands. That word holds the new bits at the top and the older bits moved down beneath them.
- R7: A one-cycle high on cal_clear clears bit 3 of register 1 at the next system clock edge and leaves every other bit unchanged.
- R8: If cal_clear and a write to register 1 take effect on the same edge, register 1 takes the written word with bit 3 forced to 0.
- R9: The field ports always show the register bits: gain_code = reg0[14:10], cutoff_code = reg0[21:15], cal_auto = reg1[2], cal_start = reg1[3], idac_code = reg1[11:4], qdac_code = reg1[19:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, low bit first |
| ser_strobe | input | 1 | Load strobe, commits on its rising edge |
| cal_clear | input | 1 | One-cycle clear of the start bit from calibration logic |
| reg0_q | output | 32 | Register 0 word |
| reg1_q | output | 32 | Register 1 word |
| gain_code | output | 5 | Gain field of register 0 |
| cutoff_code | output | 7 | Filter cutoff field of register 0 |
| cal_start | output | 1 | Start bit of register 1 |
| cal_auto | output | 1 | Automatic mode bit of register 1 |
| idac_code | output | 8 | I-channel DAC field of register 1 |
| qdac_code | output | 8 | Q-channel DAC field of register 1 |

## Verification
The assertions watch the internal shift and commit pulses on every cycle. They check that each shift moves the word down one place, that the word holds between shifts, that a commit goes only to the addressed register, that addresses 2 and 3 are dropped, and that the start bit is cleared, including when a write lands on the same edge. Other behaviours show only in the bench's scenarios: the reset words, the bit order of a whole word sent over the port, the indifference to data changes while the serial clock is high, short words, and the exact edge on which a clear meets a write.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 2;

  localparam int GAIN_LO   = 10;
  localparam int GAIN_W    = 5;
  localparam int CUT_LO    = 15;
  localparam int CUT_W     = 7;
  localparam int AUTO_BIT  = 2;
  localparam int START_BIT = 3;
  localparam int IDAC_LO   = 4;
  localparam int QDAC_LO   = 12;
  localparam int DAC_W     = 8;

  function automatic logic [WORD_W-1:0] reg0_reset_word();
    logic [WORD_W-1:0] w;
    w = '0;
    w[4] = 1'b1;
    w[9:8] = 2'b11;
    w[GAIN_LO +: GAIN_W] = 5'd15;
    w[CUT_LO +: CUT_W] = 7'd85;
    w[22] = 1'b1;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] reg1_reset_word();
    logic [WORD_W-1:0] w;
    w = '0;
    w[0] = 1'b1;
    w[AUTO_BIT] = 1'b1;
    w[IDAC_LO +: DAC_W] = 8'd128;
    w[QDAC_LO +: DAC_W] = 8'd128;
    w[23:20] = 4'hF;
    w[24] = 1'b1;
    w[28] = 1'b1;
    w[31:29] = 3'd3;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] shift_in_low_first(
    input logic [WORD_W-1:0] cur, input logic bit_in);
    return {bit_in, cur[WORD_W-1:1]};
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [WORD_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_rise_det.sv
module cfg_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise_out
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level_in;

  assign rise_out = level_in & ~level_d;
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg
  import cfg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_out
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        word_out <= '0;
    else if (shift_en) word_out <= shift_in_low_first(word_out, bit_in);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] word_in,
  input  logic              cal_clear,
  output logic [WORD_W-1:0] reg0_out,
  output logic [WORD_W-1:0] reg1_out
);
  localparam logic [WORD_W-1:0] RST0 = reg0_reset_word();
  localparam logic [WORD_W-1:0] RST1 = reg1_reset_word();

  logic              wr0, wr1;
  logic [WORD_W-1:0] reg1_next;

  assign wr0 = commit && (word_addr(word_in) == ADDR_W'(0));
  assign wr1 = commit && (word_addr(word_in) == ADDR_W'(1));

  always_comb begin
    reg1_next = wr1 ? word_in : reg1_out;
    if (cal_clear) reg1_next[START_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   reg0_out <= RST0;
    else if (wr0) reg0_out <= word_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg1_out <= RST1;
    else        reg1_out <= reg1_next;
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_strobe,
  input  logic              cal_clear,
  output logic [WORD_W-1:0] reg0_q,
  output logic [WORD_W-1:0] reg1_q,
  output logic [GAIN_W-1:0] gain_code,
  output logic [CUT_W-1:0]  cutoff_code,
  output logic              cal_start,
  output logic              cal_auto,
  output logic [DAC_W-1:0]  idac_code,
  output logic [DAC_W-1:0]  qdac_code
);
  logic [2:0]        lines_sync;
  logic              clk_sync, data_sync, strobe_sync;
  logic              shift_pulse, commit_pulse;
  logic [WORD_W-1:0] sr_word;

  cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_strobe, ser_data, ser_clk}),
    .sync_out(lines_sync)
  );

  assign clk_sync    = lines_sync[0];
  assign data_sync   = lines_sync[1];
  assign strobe_sync = lines_sync[2];

  cfg_rise_det u_clk_rise (
    .clk(clk), .rst_n(rst_n), .level_in(clk_sync), .rise_out(shift_pulse)
  );

  cfg_rise_det u_stb_rise (
    .clk(clk), .rst_n(rst_n), .level_in(strobe_sync), .rise_out(commit_pulse)
  );

  cfg_shift_reg u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_pulse),
    .bit_in(data_sync), .word_out(sr_word)
  );

  cfg_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit_pulse), .word_in(sr_word),
    .cal_clear(cal_clear), .reg0_out(reg0_q), .reg1_out(reg1_q)
  );

  assign gain_code   = reg0_q[GAIN_LO +: GAIN_W];
  assign cutoff_code = reg0_q[CUT_LO +: CUT_W];
  assign cal_auto    = reg1_q[AUTO_BIT];
  assign cal_start   = reg1_q[START_BIT];
  assign idac_code   = reg1_q[IDAC_LO +: DAC_W];
  assign qdac_code   = reg1_q[QDAC_LO +: DAC_W];
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         shift_pulse,
  input logic         data_sync,
  input logic         commit_pulse,
  input logic [W-1:0] sr_word,
  input logic         cal_clear,
  input logic [W-1:0] reg0_q,
  input logic [W-1:0] reg1_q
);
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> sr_word == {$past(data_sync), $past(sr_word[W-1:1])});

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(sr_word));

  p_commit0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && sr_word[1:0] == 2'd0) |=> reg0_q == $past(sr_word));

  p_commit1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && sr_word[1:0] == 2'd1 && !cal_clear) |=> reg1_q == $past(sr_word));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |=> $stable(reg0_q));

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && sr_word[1] && !cal_clear) |=> $stable(reg0_q) && $stable(reg1_q));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_clear |=> !reg1_q[3]);

  p_clear_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_clear && !commit_pulse) |=>
      (reg1_q[W-1:4] == $past(reg1_q[W-1:4])) && (reg1_q[2:0] == $past(reg1_q[2:0])));

  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_clear && commit_pulse && sr_word[1:0] == 2'd1) |=>
      reg1_q == ($past(sr_word) & ~W'(8)));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(.W(32)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_pulse(shift_pulse), .data_sync(data_sync),
  .commit_pulse(commit_pulse), .sr_word(sr_word), .cal_clear(cal_clear),
  .reg0_q(reg0_q), .reg1_q(reg1_q)
);

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0, cal_clear = 1'b0;
  logic [31:0] reg0_q, reg1_q;
  logic [4:0]  gain_code;
  logic [6:0]  cutoff_code;
  logic        cal_start, cal_auto;
  logic [7:0]  idac_code, qdac_code;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_serial_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .cal_clear(cal_clear), .reg0_q(reg0_q),
    .reg1_q(reg1_q), .gain_code(gain_code), .cutoff_code(cutoff_code),
    .cal_start(cal_start), .cal_auto(cal_auto), .idac_code(idac_code),
    .qdac_code(qdac_code)
  );

  localparam logic [31:0] RST0 = 32'h006A_BF10;
  localparam logic [31:0] RST1 = 32'h71F8_0805;

  // Behavioural reference: input history queues, two-cycle visibility.
  bit hc[$], hd[$], hs[$];
  logic [31:0] m_r0, m_r1, m_sr;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = '{0, 0, 0}; hd = '{0, 0, 0}; hs = '{0, 0, 0};
      m_r0 = RST0; m_r1 = RST1; m_sr = '0;
    end else begin
      bit clk_edge, stb_edge, dbit;
      clk_edge = hc[1] && !hc[0];
      stb_edge = hs[1] && !hs[0];
      dbit     = hd[1];
      if (stb_edge) begin
        case (m_sr % 4)
          0: m_r0 = m_sr;
          1: m_r1 = m_sr;
          default: ;
        endcase
      end
      if (cal_clear) m_r1 = m_r1 & ~32'd8;
      if (clk_edge) m_sr = (m_sr >> 1) | (32'(dbit) << 31);
      void'(hc.pop_front()); hc.push_back(ser_clk);
      void'(hd.pop_front()); hd.push_back(ser_data);
      void'(hs.pop_front()); hs.push_back(ser_strobe);
    end
  end

  // R4: registers compared with the reference on every clock.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (reg0_q !== m_r0 || reg1_q !== m_r1) begin
        errors++;
        $display("FAIL R4 model: reg0=%h reg1=%h expected reg0=%h reg1=%h",
                 reg0_q, reg1_q, m_r0, m_r1);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    ser_data = b; tick(1);
    ser_clk = 1'b1; tick(1);
    if (glitch) ser_data = ~b;
    tick(2);
    ser_clk = 1'b0; tick(2);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n, input bit glitch);
    for (int i = 0; i < n; i++) send_bit(w[i], glitch);
  endtask

  task automatic pulse_strobe();
    ser_strobe = 1'b1; tick(3);
    ser_strobe = 1'b0; tick(4);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset words
    check("R1 reg0 reset", reg0_q, 32'h006A_BF10);
    check("R1 reg1 reset", reg1_q, 32'h71F8_0805);
    // R9 field ports at reset
    check("R9 gain reset", 32'(gain_code), 32'd15);
    check("R9 cutoff reset", 32'(cutoff_code), 32'd85);
    check("R9 idac reset", 32'(idac_code), 32'd128);
    check("R9 qdac reset", 32'(qdac_code), 32'd128);

    // R2/R4 full word to register 0
    w = 32'hA5C3_3C50;
    send_bits(w, 32, 0); pulse_strobe();
    check("R2 reg0 word", reg0_q, w);
    check("R4 reg1 untouched", reg1_q, 32'h71F8_0805);
    check("R9 gain field", 32'(gain_code), 32'(w[14:10]));
    check("R9 cutoff field", 32'(cutoff_code), 32'(w[21:15]));

    // R4 word to register 1 with start bit, then R7 clear
    w = 32'h1234_567D;
    send_bits(w, 32, 0); pulse_strobe();
    check("R4 reg1 word", reg1_q, w);
    check("R9 start bit", 32'(cal_start), 32'd1);
    check("R9 idac field", 32'(idac_code), 32'(w[11:4]));
    cal_clear = 1'b1; tick(1); cal_clear = 1'b0; tick(1);
    check("R7 start cleared", reg1_q, w & ~32'd8);

    // R5 unused addresses
    send_bits(32'hFFFF_FFFE, 32, 0); pulse_strobe();
    check("R5 addr2 reg0", reg0_q, 32'hA5C3_3C50);
    check("R5 addr2 reg1", reg1_q, 32'h1234_5675);
    send_bits(32'hFFFF_FFFF, 32, 0); pulse_strobe();
    check("R5 addr3 reg0", reg0_q, 32'hA5C3_3C50);
    check("R5 addr3 reg1", reg1_q, 32'h1234_5675);

    // R6 short word after a full one
    send_bits(32'h0000_0010, 32, 0); pulse_strobe();
    check("R6 prior word", reg0_q, 32'h0000_0010);
    send_bits(32'h0000_000B, 4, 0); pulse_strobe();
    check("R6 short word reg1", reg1_q, 32'hB000_0001);

    // R3 data changes while serial clock high are ignored
    w = 32'h5A5A_0F0C;
    send_bits(w, 32, 1); pulse_strobe();
    check("R3 glitch word", reg0_q, w);

    // R8 clear on the same edge as a register 1 write
    w = 32'h0F0F_F00D;
    send_bits(w, 32, 0);
    ser_strobe = 1'b1; tick(2);
    cal_clear = 1'b1; tick(1);
    cal_clear = 1'b0; tick(1);
    ser_strobe = 1'b0; tick(4);
    check("R8 write with clear", reg1_q, w & ~32'd8);
    check("R8 start port", 32'(cal_start), 32'd0);
    check("R9 auto bit", 32'(cal_auto), 32'd1);

    done = 1;
    summary();
    $finish;
  end
endmodule